// File: doc/BRIEF.md
# Auto-Negotiation Page Arbiter

This block arbitrates the page exchange of backplane auto-negotiation. When a link sequencer signals that the ability-detect phase is starting, the arbiter holds the transmitter off for a break-link interval. It then transmits the local 48-bit base page and waits for the partner's page. It acknowledges that page, and it either waits for the partner's acknowledgement or finds it already received. After the exchange it decides whether next pages must follow. Serial line coding and the choice of a common technology are handled elsewhere; this block reports completion even when the two advertised technologies differ.

The arbiter has seven named states, and exactly one of them is reported on a one-hot vector:

- `ST_IDLE` (bit 0): the arbiter is armed.
- `ST_BRK` (bit 1): the break-link interval.
- `ST_ABIL` (bit 2): the base page is sent and the arbiter waits for the partner's page.
- `ST_WACK` (bit 3): the arbiter waits for the partner's acknowledgement.
- `ST_CACK` (bit 4): acknowledgements have been exchanged both ways.
- `ST_NEXT` (bit 5): the next-page exchange.
- `ST_GOOD` (bit 6): negotiation is complete.

The transitions are:

- `ST_IDLE` to `ST_BRK` when the start input is high.
- `ST_BRK` to `ST_ABIL` when the timer expires.
- `ST_ABIL` or `ST_NEXT` to `ST_CACK` when a page arrives and an acknowledgement is already in hand.
- `ST_ABIL` or `ST_NEXT` to `ST_WACK` when a page arrives and no acknowledgement has been seen yet.
- `ST_WACK` to `ST_CACK` when the acknowledgement is detected.
- `ST_CACK` to `ST_NEXT` when a next page is requested.
- `ST_CACK` to `ST_GOOD` when no next page is requested.
- Any state to `ST_IDLE` on abort.

Top module: `an_page_arbiter`

## Requirements
- R1: `state_oh` always has exactly one bit set. The bit order is `ST_IDLE`=0, `ST_BRK`=1, `ST_ABIL`=2, `ST_WACK`=3, `ST_CACK`=4, `ST_NEXT`=5, `ST_GOOD`=6.
- R2: After reset, `state_oh` is 0x01, `tx_disable` is 1 and `an_done` is 0. A cycle with `abl_start` high in `ST_IDLE` moves the arbiter to `ST_BRK` at the next edge.
- R3: `ST_BRK` lasts exactly BRK_CYCLES clock cycles with `tx_disable` high, whether or not a partner is present. Received pages and acknowledgements arriving during this interval are ignored.
- R4: When `ST_BRK` ends, the arbiter enters `ST_ABIL` with `tx_disable` low. `tx_page` then equals `loc_base_page` with bit 14 (the ACK bit) cleared.
- R5: In `ST_ABIL`, an `rx_page_vld` cycle moves the arbiter to `ST_CACK` if `rx_ack_det` was seen earlier in this state or is seen in the same cycle. Otherwise it moves to `ST_WACK`. In `ST_WACK`, `ST_CACK` and `ST_GOOD`, the transmitted bit 14 is 1.
- R6: In `ST_WACK`, the arbiter stays until `rx_ack_det` is high and then moves to `ST_CACK`.
- R7: `ST_CACK` lasts one cycle. If bit 15 (the NP bit) was set in the last page sent or in the last page received, the next state is `ST_NEXT`; otherwise it is `ST_GOOD`.
- R8: On entry to `ST_NEXT`, `tx_page` becomes `loc_np_page` if `loc_np_req` is high, or else the null page 0x000000000001. The ACK bit is cleared. The same page-then-acknowledge handshake as in R5 and R6 follows, and it can repeat any number of times.
- R9: `ST_GOOD` asserts `an_done` and holds it regardless of the page contents, including mismatched technologies.
- R10: `an_en` low or `an_restart` high returns the arbiter to `ST_IDLE` at the next edge and clears `an_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| an_en | input | 1 | Negotiation enable; low aborts |
| an_restart | input | 1 | Restart pulse; aborts |
| abl_start | input | 1 | Ability-detect phase begins |
| loc_base_page | input | PAGE_W | Local base page |
| loc_np_req | input | 1 | Local next page pending |
| loc_np_page | input | PAGE_W | Local next page content |
| rx_page_vld | input | 1 | Partner page received this cycle |
| rx_page | input | PAGE_W | Received partner page |
| rx_ack_det | input | 1 | Partner acknowledgement detected |
| tx_disable | output | 1 | Transmitter off |
| tx_page | output | PAGE_W | Page to transmit, with the ACK bit merged in |
| state_oh | output | 7 | One-hot arbiter state |
| an_done | output | 1 | Negotiation complete |

## Verification
The bench drives the timer boundary by checking the state one cycle before and at the expiry of the break interval. A design with an off-by-one counter leaves `ST_BRK` early or late. The bench places the partner's acknowledgement before the page, in the same cycle as the page, and after the page. A design that loses an early acknowledgement stalls in `ST_WACK`. Next pages are requested once from the local side and once only from the partner's side. A design that ignores the partner's NP bit skips straight to completion, and one that fails to build the null page transmits stale data. The bench also aborts from mid-exchange and from completion, and sends pages during the break interval, which a careless design would accept.

// File: rtl/an_arb_pkg.sv
package an_arb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BRK  = 3'd1,
        ST_ABIL = 3'd2,
        ST_WACK = 3'd3,
        ST_CACK = 3'd4,
        ST_NEXT = 3'd5,
        ST_GOOD = 3'd6
    } arb_state_e;

    localparam int unsigned NUM_STATES = 7;
endpackage

// File: rtl/an_brk_timer.sv
module an_brk_timer #(
    parameter int unsigned BRK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(BRK_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(BRK_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/an_page_sel.sv
module an_page_sel #(
    parameter int unsigned PAGE_W  = 48,
    parameter int unsigned NP_BIT  = 15,
    parameter int unsigned ACK_BIT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load_base,
    input  logic              load_next,
    input  logic [PAGE_W-1:0] base_page,
    input  logic              np_req,
    input  logic [PAGE_W-1:0] np_page,
    input  logic              ack_on,
    output logic [PAGE_W-1:0] tx_page,
    output logic              tx_np
);
    localparam logic [PAGE_W-1:0] NULL_PAGE = PAGE_W'(1);

    logic [PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0] load_val;

    always_comb begin
        if (load_base) begin
            load_val = base_page;
        end else if (np_req) begin
            load_val = np_page;
        end else begin
            load_val = NULL_PAGE;
        end
        load_val[ACK_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            page_q <= '0;
        end else if (load_base || load_next) begin
            page_q <= load_val;
        end
    end

    always_comb begin
        tx_page          = page_q;
        tx_page[ACK_BIT] = ack_on;
    end

    assign tx_np = page_q[NP_BIT];
endmodule

// File: rtl/an_arb_fsm.sv
module an_arb_fsm
    import an_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       abl_start,
    input  logic       brk_expired,
    input  logic       rx_page_vld,
    input  logic       rx_np,
    input  logic       rx_ack_det,
    input  logic       tx_np,
    output arb_state_e state,
    output logic       load_base,
    output logic       load_next
);
    arb_state_e state_q;
    arb_state_e state_d;
    logic       ack_seen_q;
    logic       rx_np_q;
    logic       listening;
    logic       np_need;

    assign listening = (state_q == ST_ABIL) || (state_q == ST_NEXT);
    assign np_need   = tx_np || rx_np_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (abl_start)   state_d = ST_BRK;
            ST_BRK:  if (brk_expired) state_d = ST_ABIL;
            ST_ABIL, ST_NEXT: begin
                if (rx_page_vld) begin
                    state_d = (ack_seen_q || rx_ack_det) ? ST_CACK : ST_WACK;
                end
            end
            ST_WACK: if (rx_ack_det) state_d = ST_CACK;
            ST_CACK: state_d = np_need ? ST_NEXT : ST_GOOD;
            ST_GOOD: state_d = ST_GOOD;
            default: state_d = ST_IDLE;
        endcase
        if (abort) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE || load_next) begin
            ack_seen_q <= 1'b0;
        end else if (listening && rx_ack_det) begin
            ack_seen_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) begin
            rx_np_q <= 1'b0;
        end else if (listening && rx_page_vld) begin
            rx_np_q <= rx_np;
        end
    end

    assign state     = state_q;
    assign load_base = !abort && (state_q == ST_BRK) && brk_expired;
    assign load_next = !abort && (state_q == ST_CACK) && np_need;
endmodule

// File: rtl/an_page_arbiter.sv
module an_page_arbiter
    import an_arb_pkg::*;
#(
    parameter int unsigned PAGE_W     = 48,
    parameter int unsigned NP_BIT     = 15,
    parameter int unsigned ACK_BIT    = 14,
    parameter int unsigned BRK_CYCLES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  an_en,
    input  logic                  an_restart,
    input  logic                  abl_start,
    input  logic [PAGE_W-1:0]     loc_base_page,
    input  logic                  loc_np_req,
    input  logic [PAGE_W-1:0]     loc_np_page,
    input  logic                  rx_page_vld,
    input  logic [PAGE_W-1:0]     rx_page,
    input  logic                  rx_ack_det,
    output logic                  tx_disable,
    output logic [PAGE_W-1:0]     tx_page,
    output logic [NUM_STATES-1:0] state_oh,
    output logic                  an_done
);
    arb_state_e state;
    logic       abort;
    logic       brk_expired;
    logic       load_base;
    logic       load_next;
    logic       tx_np;
    logic       ack_on;

    assign abort = !an_en || an_restart;

    an_brk_timer #(.BRK_CYCLES(BRK_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_BRK),
        .expired (brk_expired)
    );

    an_arb_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (abort),
        .abl_start   (abl_start),
        .brk_expired (brk_expired),
        .rx_page_vld (rx_page_vld),
        .rx_np       (rx_page[NP_BIT]),
        .rx_ack_det  (rx_ack_det),
        .tx_np       (tx_np),
        .state       (state),
        .load_base   (load_base),
        .load_next   (load_next)
    );

    assign ack_on = (state == ST_WACK) || (state == ST_CACK) || (state == ST_GOOD);

    an_page_sel #(
        .PAGE_W  (PAGE_W),
        .NP_BIT  (NP_BIT),
        .ACK_BIT (ACK_BIT)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (state == ST_IDLE),
        .load_base (load_base),
        .load_next (load_next),
        .base_page (loc_base_page),
        .np_req    (loc_np_req),
        .np_page   (loc_np_page),
        .ack_on    (ack_on),
        .tx_page   (tx_page),
        .tx_np     (tx_np)
    );

    for (genvar s = 0; s < NUM_STATES; s++) begin : g_oh
        assign state_oh[s] = (state == arb_state_e'(s));
    end

    assign tx_disable = (state == ST_IDLE) || (state == ST_BRK);
    assign an_done    = (state == ST_GOOD);
endmodule

// File: rtl/an_page_arbiter_chk.sv
module an_page_arbiter_chk #(
    parameter int unsigned PAGE_W     = 48,
    parameter int unsigned ACK_BIT    = 14,
    parameter int unsigned BRK_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              an_en,
    input logic              an_restart,
    input logic              rx_page_vld,
    input logic              rx_ack_det,
    input logic              tx_disable,
    input logic [PAGE_W-1:0] tx_page,
    input logic [6:0]        state_oh,
    input logic              an_done
);
    logic abort;
    int   brk_len;

    assign abort = !an_en || an_restart;

    always_ff @(posedge clk) begin
        if (!rst_n || !state_oh[1]) begin
            brk_len <= state_oh[1] ? 1 : 0;
        end else begin
            brk_len <= brk_len + 1;
        end
    end

    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_oh));

    assert_brk_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_oh[1]) && state_oh[2] |-> brk_len == BRK_CYCLES);

    assert_page_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh[2] && rx_page_vld && !abort |=> state_oh[3] || state_oh[4]);

    assert_ack_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh[3] && rx_ack_det && !abort |=> state_oh[4]);

    assert_cack_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_oh[4] && !abort |=> state_oh[5] || state_oh[6]);

    assert_done_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        an_done |-> tx_page[ACK_BIT] && !tx_disable);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        an_done && !abort |=> an_done);

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> state_oh[0] && !an_done);
endmodule

bind an_page_arbiter an_page_arbiter_chk #(
    .PAGE_W     (PAGE_W),
    .ACK_BIT    (ACK_BIT),
    .BRK_CYCLES (BRK_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .an_en       (an_en),
    .an_restart  (an_restart),
    .rx_page_vld (rx_page_vld),
    .rx_ack_det  (rx_ack_det),
    .tx_disable  (tx_disable),
    .tx_page     (tx_page),
    .state_oh    (state_oh),
    .an_done     (an_done)
);

// File: tb/test_an_page_arbiter.sv
`timescale 1ns/1ps
module test_an_page_arbiter;
    localparam int unsigned PW  = 48;
    localparam int unsigned BRK = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          an_en = 1'b1;
    logic          an_restart = 1'b0;
    logic          abl_start = 1'b0;
    logic [PW-1:0] loc_base_page = '0;
    logic          loc_np_req = 1'b0;
    logic [PW-1:0] loc_np_page = '0;
    logic          rx_page_vld = 1'b0;
    logic [PW-1:0] rx_page = '0;
    logic          rx_ack_det = 1'b0;
    logic          tx_disable;
    logic [PW-1:0] tx_page;
    logic [6:0]    state_oh;
    logic          an_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    an_page_arbiter #(.PAGE_W(PW), .BRK_CYCLES(BRK)) i_an_page_arbiter (
        .clk(clk), .rst_n(rst_n), .an_en(an_en), .an_restart(an_restart),
        .abl_start(abl_start), .loc_base_page(loc_base_page),
        .loc_np_req(loc_np_req), .loc_np_page(loc_np_page),
        .rx_page_vld(rx_page_vld), .rx_page(rx_page), .rx_ack_det(rx_ack_det),
        .tx_disable(tx_disable), .tx_page(tx_page), .state_oh(state_oh),
        .an_done(an_done)
    );

    localparam logic [6:0] S_IDLE = 7'h01, S_BRK = 7'h02, S_ABIL = 7'h04,
                           S_WACK = 7'h08, S_CACK = 7'h10, S_NEXT = 7'h20,
                           S_GOOD = 7'h40;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] noack(input logic [PW-1:0] p);
        logic [PW-1:0] r = p;
        r[14] = 1'b0;
        return r;
    endfunction

    function automatic logic [PW-1:0] withack(input logic [PW-1:0] p);
        logic [PW-1:0] r = p;
        r[14] = 1'b1;
        return r;
    endfunction

    task automatic abort_now();
        an_restart = 1'b1;
        step();
        an_restart = 1'b0;
        chk(state_oh, S_IDLE, "R10 restart to idle");
        chk(an_done, 0, "R10 done cleared");
    endtask

    // Start, cover the break interval, end in ST_ABIL.
    task automatic run_break(input logic [PW-1:0] base);
        loc_base_page = base;
        abl_start = 1'b1;
        step();
        abl_start = 1'b0;
        chk(state_oh, S_BRK, "R2 start to break");
        chk(tx_disable, 1, "R3 tx off in break");
        for (int i = 1; i < BRK; i++) begin
            if (i == 5) begin
                rx_page_vld = 1'b1;
                rx_ack_det = 1'b1;
            end
            step();
            rx_page_vld = 1'b0;
            rx_ack_det = 1'b0;
            if (i == 5 || i == BRK - 1) chk(state_oh, S_BRK, "R3 still in break");
        end
        step();
        chk(state_oh, S_ABIL, "R4 break ends");
        chk(tx_disable, 0, "R4 tx on");
        chk(tx_page, noack(base), "R4 base page sent, ack clear");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        chk(state_oh, S_IDLE, "R2 reset state");
        chk(tx_disable, 1, "R2 reset tx off");
        chk(an_done, 0, "R2 reset done low");
        step();
        chk(state_oh, S_IDLE, "R1 idle holds without start");
    endtask

    task automatic t_ack_same_cycle();
        logic [PW-1:0] base = 48'h1234_0000_00A1;
        run_break(base);
        rx_page = 48'h0000_0000_0081;
        rx_page_vld = 1'b1;
        rx_ack_det = 1'b1;
        step();
        rx_page_vld = 1'b0;
        rx_ack_det = 1'b0;
        chk(state_oh, S_CACK, "R5 ack with page to cack");
        chk(tx_page, withack(base), "R5 ack bit sent");
        step();
        chk(state_oh, S_GOOD, "R7 no NP to good");
        chk(an_done, 1, "R9 done asserted on mismatch");
        step();
        chk(an_done, 1, "R9 done holds");
        abort_now();
    endtask

    task automatic t_ack_late();
        run_break(48'h0000_0000_0011);
        step();
        chk(state_oh, S_ABIL, "R5 waits for partner page");
        rx_page = 48'h0000_0000_0011;
        rx_page_vld = 1'b1;
        step();
        rx_page_vld = 1'b0;
        chk(state_oh, S_WACK, "R5 no ack to wack");
        chk(tx_page[14], 1, "R5 ack bit high in wack");
        step(); step();
        chk(state_oh, S_WACK, "R6 waits in wack");
        rx_ack_det = 1'b1;
        step();
        rx_ack_det = 1'b0;
        chk(state_oh, S_CACK, "R6 ack to cack");
        step();
        chk(state_oh, S_GOOD, "R7 cack to good");
        an_en = 1'b0;
        step();
        an_en = 1'b1;
        chk(state_oh, S_IDLE, "R10 disable from good");
        chk(an_done, 0, "R10 disable clears done");
    endtask

    task automatic t_early_ack();
        run_break(48'h0000_0000_0022);
        rx_ack_det = 1'b1;
        step();
        rx_ack_det = 1'b0;
        step();
        rx_page_vld = 1'b1;
        step();
        rx_page_vld = 1'b0;
        chk(state_oh, S_CACK, "R5 earlier ack remembered");
        step();
        chk(state_oh, S_GOOD, "R7 good after early ack");
        abort_now();
    endtask

    task automatic t_local_next();
        logic [PW-1:0] base = 48'h0000_0000_8001;
        logic [PW-1:0] np   = 48'hABCD_0000_2005;
        run_break(base);
        loc_np_req = 1'b1;
        loc_np_page = np;
        rx_page = 48'h0000_0000_0001;
        rx_page_vld = 1'b1;
        rx_ack_det = 1'b1;
        step();
        rx_page_vld = 1'b0;
        rx_ack_det = 1'b0;
        step();
        chk(state_oh, S_NEXT, "R7 local NP to next");
        chk(tx_page, noack(np), "R8 local next page sent");
        rx_page = 48'h0000_0000_0001;
        rx_page_vld = 1'b1;
        step();
        rx_page_vld = 1'b0;
        loc_np_req = 1'b0;
        chk(state_oh, S_WACK, "R8 next page waits ack");
        rx_ack_det = 1'b1;
        step();
        rx_ack_det = 1'b0;
        step();
        chk(state_oh, S_GOOD, "R8 next exchange ends good");
        abort_now();
    endtask

    task automatic t_null_next();
        run_break(48'h0000_0000_0001);
        loc_np_req = 1'b0;
        loc_np_page = 48'hFFFF_FFFF_FFFF;
        rx_page = 48'h0000_0000_8001;
        rx_page_vld = 1'b1;
        rx_ack_det = 1'b1;
        step();
        rx_page_vld = 1'b0;
        rx_ack_det = 1'b0;
        step();
        chk(state_oh, S_NEXT, "R7 partner NP to next");
        chk(tx_page, 48'h0000_0000_0001, "R8 null page sent");
        rx_page = 48'h0000_0000_8001;
        rx_page_vld = 1'b1;
        rx_ack_det = 1'b1;
        step();
        rx_page_vld = 1'b0;
        rx_ack_det = 1'b0;
        step();
        chk(state_oh, S_NEXT, "R8 second next page loop");
        rx_page = 48'h0000_0000_0001;
        rx_page_vld = 1'b1;
        rx_ack_det = 1'b1;
        step();
        rx_page_vld = 1'b0;
        rx_ack_det = 1'b0;
        step();
        chk(state_oh, S_GOOD, "R8 loop ends good");
        abort_now();
    endtask

    task automatic t_abort_mid();
        run_break(48'h0000_0000_0003);
        rx_page_vld = 1'b1;
        step();
        rx_page_vld = 1'b0;
        chk(state_oh, S_WACK, "R5 wack before abort");
        abort_now();
        chk(tx_disable, 1, "R10 tx off after abort");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_ack_same_cycle();
        t_ack_late();
        t_early_ack();
        t_local_next();
        t_null_next();
        t_abort_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule